// File: doc/BRIEF.md
# Bidirectional Bus Transceiver with Parity Generation and Checking

This block joins two byte-wide buses, side A and side B, and passes data across in one direction at a time. A direction input picks the way data flows. A single parity pin works in both directions. When data flows from A to B, the pin is an output that carries parity generated from the A-side byte. When data flows from B to A, the pin is an input, and the block checks it against the B-side byte. The check result appears on an active-low error output.

Every pin is modelled as separate input, output and output-enable signals, so the block can sit behind real pad cells or inside a simulated bus. A global active-low enable releases every bus-facing output. The parity logic is combinational. The parameter `REG_OUT` can add one register stage on all driven values and their enables. This stage is on by default and resets synchronously to "everything undriven".

When an output's enable is low, the block also drives that output's value to zero. A bus monitor therefore never sees stale data on a released pin.

Top module: `bus_xcvr_parity`

## Requirements
- R1: While `rst_n` is low at a clock edge (REG_OUT=1), every output value and every output enable is 0 after that edge.
- R2: When `oe_n` is 1, `a_oe`, `b_oe`, `par_oe` and `err_oe` are all 0, and `a_out`, `b_out`, `par_out`, `err_n` are all 0, whatever the other inputs are.
- R3: With `oe_n`=0 and `dir_tx`=1, `b_oe`=1, `a_oe`=0 and `b_out` equals `a_in` bit for bit, with no inversion.
- R4: With `oe_n`=0 and `dir_tx`=0, `a_oe`=1, `b_oe`=0 and `a_out` equals `b_in` bit for bit, with no inversion.
- R5: `par_oe` is 1 exactly when `oe_n`=0 and `dir_tx`=1. In every other mode the parity pin is released.
- R6: When transmitting, `odd_sel`=0 selects even parity: `par_out` is 1 when `a_in` has an odd number of ones, and 0 otherwise. `odd_sel`=1 selects odd parity and inverts that result.
- R7: When receiving, `err_oe`=1. `err_n` is 1 (no error) when the ones in `b_in` plus `par_in` add up to an even count under `odd_sel`=0, or to an odd count under `odd_sel`=1. Otherwise `err_n` is 0.
- R8: When transmitting, `err_oe`=1 and `err_n`=1. The value on `par_in` has no effect on any output.
- R9: With REG_OUT=1, every output reflects the inputs sampled at the previous rising clock edge. A change of inputs between edges does not show on the outputs until the next edge.
- R10: `a_oe` and `b_oe` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset |
| oe_n | input | 1 | Global active-low output enable |
| dir_tx | input | 1 | 1: A to B (transmit), 0: B to A (receive) |
| odd_sel | input | 1 | 0: even parity, 1: odd parity |
| a_in | input | DATA_W | Side A pin input values |
| a_out | output | DATA_W | Side A pin drive values |
| a_oe | output | 1 | Side A drive enable |
| b_in | input | DATA_W | Side B pin input values |
| b_out | output | DATA_W | Side B pin drive values |
| b_oe | output | 1 | Side B drive enable |
| par_in | input | 1 | Parity pin input value (used when receiving) |
| par_out | output | 1 | Parity pin drive value (generated when transmitting) |
| par_oe | output | 1 | Parity pin drive enable |
| err_n | output | 1 | Active-low parity error flag |
| err_oe | output | 1 | Error pin drive enable |

## Verification
The bench covers several corner cases, each with a typical failure it would catch:
- Released state: a design that gated only the enables would leak data onto released pins. The bench tests every combination of enable and direction.
- Parity sense: a swapped even/odd sense would flip both `par_out` and `err_n`. The bench uses all-zero and all-ones bytes, where the parity count is easy to predict.
- Transmit errors: a checker left active while transmitting would pull `err_n` low. The bench toggles `par_in` in transmit mode and watches `err_n`.
- Timing and reset: the bench compares outputs just before and just after an edge to catch a missing register stage. It asserts reset in the middle of traffic to catch a reset that fails to release the buses.

// File: rtl/xcvr_pkg.sv
// Shared types for the bus transceiver.
// Assumes: nothing; pure type and helper definitions.
package xcvr_pkg;

    // Operating mode decoded from the enable and direction inputs.
    typedef enum logic [1:0] {
        MODE_OFF = 2'b00,
        MODE_TX  = 2'b01,
        MODE_RX  = 2'b10
    } xcvr_mode_e;

    // Count of single-bit fields carried next to the two data words.
    localparam int CTRL_BITS = 6;

endpackage

// File: rtl/xcvr_mode_dec.sv
// Decodes the global enable and direction inputs into one mode value.
// Assumes: oe_n is active low and overrides the direction input.
module xcvr_mode_dec
    import xcvr_pkg::*;
(
    input  logic       oe_n,
    input  logic       dir_tx,
    output xcvr_mode_e mode
);

    // Select the mode: disable wins, then direction chooses.
    always_comb begin
        if (oe_n)        mode = MODE_OFF;
        else if (dir_tx) mode = MODE_TX;
        else             mode = MODE_RX;
    end

endmodule

// File: rtl/xcvr_parity_tree.sv
// Reduces a data word to its XOR parity (1 when the count of ones is odd).
// Assumes: WIDTH >= 1.
module xcvr_parity_tree #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] data,
    output logic             odd_ones
);

    logic [WIDTH:0] acc;

    assign acc[0] = 1'b0;

    // One XOR stage per data bit, chained.
    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        assign acc[i+1] = acc[i] ^ data[i];
    end

    assign odd_ones = acc[WIDTH];

endmodule

// File: rtl/xcvr_out_stage.sv
// Optional output register for all pin values and enables.
// Assumes: a reset value of all zeros means every pin is released.
module xcvr_out_stage #(
    parameter int WIDTH   = 8,
    parameter bit REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    if (REG_OUT) begin : g_reg
        logic [WIDTH-1:0] q_r;

        // Capture the next pin state each edge; a synchronous reset releases all pins.
        always_ff @(posedge clk) begin
            if (!rst_n) q_r <= '0;
            else        q_r <= d;
        end

        assign q = q_r;
    end else begin : g_comb
        assign q = d;
    end

endmodule

// File: rtl/bus_xcvr_parity.sv
// Byte-wide bidirectional transceiver with a shared parity pin.
// Transmit (dir_tx=1): A drives B and the parity pin carries generated parity.
// Receive  (dir_tx=0): B drives A, and the parity pin is checked along with B.
// Assumes: the pins are split into in/out/oe; released outputs carry value 0.
module bus_xcvr_parity
    import xcvr_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              oe_n,
    input  logic              dir_tx,
    input  logic              odd_sel,
    input  logic [DATA_W-1:0] a_in,
    output logic [DATA_W-1:0] a_out,
    output logic              a_oe,
    input  logic [DATA_W-1:0] b_in,
    output logic [DATA_W-1:0] b_out,
    output logic              b_oe,
    input  logic              par_in,
    output logic              par_out,
    output logic              par_oe,
    output logic              err_n,
    output logic              err_oe
);

    localparam int PACK_W = 2 * DATA_W + CTRL_BITS;

    xcvr_mode_e        mode;
    logic              a_odd;
    logic              b_odd;
    logic              is_tx;
    logic              is_rx;
    logic [DATA_W-1:0] a_nxt;
    logic [DATA_W-1:0] b_nxt;
    logic              par_nxt;
    logic              err_nxt;
    logic [PACK_W-1:0] pins_nxt;
    logic [PACK_W-1:0] pins_q;

    xcvr_mode_dec u_mode (
        .oe_n   (oe_n),
        .dir_tx (dir_tx),
        .mode   (mode)
    );

    xcvr_parity_tree #(.WIDTH(DATA_W)) u_par_a (
        .data     (a_in),
        .odd_ones (a_odd)
    );

    xcvr_parity_tree #(.WIDTH(DATA_W)) u_par_b (
        .data     (b_in),
        .odd_ones (b_odd)
    );

    assign is_tx = (mode == MODE_TX);
    assign is_rx = (mode == MODE_RX);

    // Build next pin values; every released pin is forced to zero.
    always_comb begin
        a_nxt   = is_rx ? b_in : '0;
        b_nxt   = is_tx ? a_in : '0;
        par_nxt = is_tx & (a_odd ^ odd_sel);
        if (is_tx)      err_nxt = 1'b1;
        else if (is_rx) err_nxt = ~(b_odd ^ par_in ^ odd_sel);
        else            err_nxt = 1'b0;
    end

    assign pins_nxt = {a_nxt, is_rx, b_nxt, is_tx, par_nxt, is_tx, err_nxt, is_tx | is_rx};

    xcvr_out_stage #(.WIDTH(PACK_W), .REG_OUT(REG_OUT)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pins_nxt),
        .q     (pins_q)
    );

    assign {a_out, a_oe, b_out, b_oe, par_out, par_oe, err_n, err_oe} = pins_q;

endmodule

// File: rtl/bus_xcvr_parity_chk.sv
// Assertion checker for bus_xcvr_parity, attached with bind.
// Assumes: with REG_OUT=1 the outputs lag the inputs by exactly one edge.
module bus_xcvr_parity_chk #(
    parameter int DATA_W  = 8,
    parameter bit REG_OUT = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              oe_n,
    input logic              dir_tx,
    input logic              odd_sel,
    input logic [DATA_W-1:0] a_in,
    input logic [DATA_W-1:0] a_out,
    input logic              a_oe,
    input logic [DATA_W-1:0] b_in,
    input logic [DATA_W-1:0] b_out,
    input logic              b_oe,
    input logic              par_in,
    input logic              par_out,
    input logic              par_oe,
    input logic              err_n,
    input logic              err_oe
);

    assert_one_port_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_oe && b_oe));

    if (REG_OUT) begin : g_seq
        assert_released_R2: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) && $past(oe_n) |->
                !a_oe && !b_oe && !par_oe && !err_oe && a_out == '0 && b_out == '0);

        assert_tx_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) && !$past(oe_n) && $past(dir_tx) |->
                b_oe && !a_oe && b_out == $past(a_in));

        assert_rx_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) && !$past(oe_n) && !$past(dir_tx) |->
                a_oe && !b_oe && a_out == $past(b_in));

        assert_par_dir_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) && !($past(dir_tx) && !$past(oe_n)) |-> !par_oe);

        assert_gen_R6: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) && !$past(oe_n) && $past(dir_tx) |->
                par_oe && (par_out == (($countones($past(a_in)) % 2 == 1) ^ $past(odd_sel))));

        assert_chk_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) && !$past(oe_n) && !$past(dir_tx) |->
                err_oe && (err_n == ((($countones($past(b_in)) + int'($past(par_in))) % 2 == 1)
                                     == $past(odd_sel))));

        assert_tx_noerr_R8: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) && !$past(oe_n) && $past(dir_tx) |-> err_oe && err_n);

        assert_reset_R1: assert property (@(posedge clk)
            !$past(rst_n) && $past(rst_n, 2) |->
                !a_oe && !b_oe && !par_oe && !err_oe);
    end else begin : g_comb
        assert_released_R2: assert property (@(posedge clk) disable iff (!rst_n)
            oe_n |-> !a_oe && !b_oe && !par_oe && !err_oe);

        assert_tx_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !oe_n && dir_tx |-> b_oe && b_out == a_in);

        assert_rx_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
            !oe_n && !dir_tx |-> a_oe && a_out == b_in);

        assert_tx_noerr_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !oe_n && dir_tx |-> err_oe && err_n);
    end

endmodule

bind bus_xcvr_parity bus_xcvr_parity_chk #(.DATA_W(DATA_W), .REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/sim_bus_xcvr_parity.sv
// Self-checking bench for bus_xcvr_parity (REG_OUT=1, one edge of latency).
module sim_bus_xcvr_parity;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         oe_n, dir_tx, odd_sel, par_in;
    logic [W-1:0] a_in, b_in;
    logic [W-1:0] a_out, b_out;
    logic         a_oe, b_oe, par_out, par_oe, err_n, err_oe;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    bus_xcvr_parity #(.DATA_W(W), .REG_OUT(1'b1)) u0 (.*);

    // Stimulus table: {oe_n, dir_tx, odd_sel, par_in, a_in, b_in}
    localparam int NV = 12;
    localparam logic [19:0] VEC [NV] = '{
        {4'b0100, 8'h00, 8'hFF}, {4'b0110, 8'h00, 8'h12},
        {4'b0100, 8'hFF, 8'h00}, {4'b0100, 8'h01, 8'h00},
        {4'b0110, 8'h01, 8'h55}, {4'b0101, 8'h7F, 8'h33},
        {4'b0001, 8'hAA, 8'h01}, {4'b0000, 8'hAA, 8'h01},
        {4'b0011, 8'h00, 8'hFF}, {4'b0010, 8'h00, 8'hFF},
        {4'b1100, 8'hC3, 8'h3C}, {4'b1011, 8'h5A, 8'hA5}
    };

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    // Reference model applied to the inputs captured at the last edge.
    task automatic check_model(input logic xo, input logic xd, input logic xs,
                               input logic xp, input logic [W-1:0] xa, input logic [W-1:0] xb);
        logic en_tx, en_rx, pa, pb;
        en_tx = !xo && xd;
        en_rx = !xo && !xd;
        pa = ($countones(xa) % 2) == 1;
        pb = (($countones(xb) + int'(xp)) % 2) == 1;
        chk("R2/R4 a_oe", int'(a_oe), int'(en_rx));
        chk("R2/R3 b_oe", int'(b_oe), int'(en_tx));
        chk("R5 par_oe", int'(par_oe), int'(en_tx));
        chk("R2 err_oe", int'(err_oe), int'(en_tx || en_rx));
        chk("R4 a_out", int'(a_out), en_rx ? int'(xb) : 0);
        chk("R3 b_out", int'(b_out), en_tx ? int'(xa) : 0);
        chk("R6 par_out", int'(par_out), en_tx ? int'(pa ^ xs) : 0);
        if (en_tx)      chk("R8 err_n", int'(err_n), 1);
        else if (en_rx) chk("R7 err_n", int'(err_n), int'(pb == xs));
        else            chk("R2 err_n", int'(err_n), 0);
        chk("R10 one side", int'(a_oe && b_oe), 0);
    endtask

    task automatic apply(input logic xo, input logic xd, input logic xs,
                         input logic xp, input logic [W-1:0] xa, input logic [W-1:0] xb);
        @(negedge clk);
        oe_n = xo; dir_tx = xd; odd_sel = xs; par_in = xp; a_in = xa; b_in = xb;
        @(posedge clk);
        #1;
        check_model(xo, xd, xs, xp, xa, xb);
    endtask

    initial begin
        rst_n = 1'b0; oe_n = 1'b0; dir_tx = 1'b1; odd_sel = 1'b0; par_in = 1'b0;
        a_in = 8'hA5; b_in = 8'h5A;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset holds every pin released and zero
        chk("R1 enables", int'({a_oe, b_oe, par_oe, err_oe}), 0);
        chk("R1 values", int'({a_out, b_out, par_out, err_n}), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk
        for (int i = 0; i < NV; i++)
            apply(VEC[i][19], VEC[i][18], VEC[i][17], VEC[i][16], VEC[i][15:8], VEC[i][7:0]);

        // Sweep of all control combinations with random data
        for (int c = 0; c < 16; c++)
            for (int r = 0; r < 8; r++)
                apply(c[3], c[2], c[1], c[0], W'($urandom), W'($urandom));

        // R8: toggling par_in during transmit has no effect on any output
        apply(1'b0, 1'b1, 1'b0, 1'b0, 8'h3B, 8'h00);
        apply(1'b0, 1'b1, 1'b0, 1'b1, 8'h3B, 8'h00);
        chk("R8 par_out unaffected", int'(par_out), 1);
        chk("R8 err_n unaffected", int'(err_n), 1);

        // R9: new inputs do not show before the next edge
        apply(1'b0, 1'b1, 1'b0, 1'b0, 8'h0F, 8'h00);
        @(negedge clk);
        a_in = 8'hF1; dir_tx = 1'b1;
        #1;
        chk("R9 held before edge", int'(b_out), 8'h0F);
        @(posedge clk);
        #1;
        chk("R9 updated after edge", int'(b_out), 8'hF1);

        // R1: reset in mid traffic releases the buses
        apply(1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 8'h77);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        chk("R1 mid-run enables", int'({a_oe, b_oe, par_oe, err_oe}), 0);
        chk("R1 mid-run a_out", int'(a_out), 0);
        @(negedge clk);
        rst_n = 1'b1;
        apply(1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 8'h77);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog
    initial begin
        #200000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule